// File: doc/BRIEF.md
# Flash Auto-Algorithm Status Interface

This block stands in for an embedded flash array while its internal program or erase algorithm runs. A CPU-side command port starts a one-byte program or a whole-array erase. A counter-driven busy sequence replaces the real cell physics, and a small behavioural byte array holds the contents. The ready line drops for the length of the sequence, and bit 0 of the status word mirrors it. When the sequence ends, a sticky interrupt flag is set. The flag drives the interrupt request only while software has enabled it.

While the algorithm runs and the programming-mode input is high, selected reads of the array return a sequence-status byte instead of data. This byte carries a data-polling bit, two read toggles, a timeout indication and an erase-setup indication. When the sequence stalls past a parameterised cycle limit, the algorithm is aborted. A short abort tail then reports the timeout before the block returns to ready.

Top module: `flash_seq_status`

## Requirements
- R1: After reset, rdy_o is 1. A command accepted while ready drives rdy_o to 0 from the next cycle. With stall_i low, rdy_o stays 0 for PROG_CYCLES cycles (program) or ERASE_CYCLES cycles (erase). status_o[0] equals rdy_o.
- R2: A command presented while rdy_o is 0 has no effect on the array, the busy length or the flags.
- R3: The interrupt flag status_o[1] becomes 1 in the cycle in which rdy_o returns to 1. It stays 1 until a status write with st_clr_i=1. irq_o is 1 only while status_o[1] and the enable status_o[2] are both 1. The enable is loaded from st_ien_i on every status write.
- R4: Reads answer one cycle later with rvalid_o. While busy with prog_mode_i=1, two kinds of read return the status byte in rdata_o[7:0] with rdata_o[31:8]=0: a byte read (rd_size_i=0) at an odd address, and a half-word read (rd_size_i=1) at any address.
- R5: While busy, byte reads at even addresses and word reads (rd_size_i=2) return array data. With prog_mode_i=0, every read returns array data. None of these reads advances the status toggles.
- R6: Status bit 7 is the inverse of bit 7 of the byte being programmed. During an erase it is 0.
- R7: Status bit 6 is 0 at the start of each command and inverts after every read that returns the status byte.
- R8: Status bit 3 is 1 during an erase once SETUP_CYCLES busy cycles have elapsed, and 0 otherwise. Status bit 2 inverts after each status read during an erase and is 0 during a program. Bits 4, 1 and 0 are 0.
- R9: A sequence that has not completed TIMEOUT_CYCLES cycles after acceptance is aborted, with the array left unchanged. The block then stays busy for ABORT_CYCLES more cycles with status bit 5 at 1, and then becomes ready, which sets the interrupt flag. status_o[3] holds 1 until the next accepted command.
- R10: Reset fills the array with 8'hFF. A completed program writes its byte, and a completed erase sets every byte to 8'hFF. A read gathers 1, 2 or 4 bytes from the address aligned to its size, with the lowest address in rdata_o[7:0] and all unused upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_mode_i | input | 1 | Programming mode; enables status-byte reads |
| stall_i | input | 1 | Holds sequence progress (slow cells) |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_erase_i | input | 1 | 1 = erase whole array, 0 = program one byte |
| cmd_addr_i | input | AW | Program address |
| cmd_data_i | input | 8 | Program data |
| rd_i | input | 1 | Read request |
| rd_size_i | input | 2 | 0 byte, 1 half-word, 2 word |
| rd_addr_i | input | AW | Read byte address |
| st_we_i | input | 1 | Status write strobe |
| st_ien_i | input | 1 | Interrupt enable value written |
| st_clr_i | input | 1 | 1 clears the interrupt flag on a status write |
| rdy_o | output | 1 | Ready (1) / busy (0) |
| irq_o | output | 1 | Interrupt request |
| status_o | output | 4 | {timeout, int enable, int flag, ready} |
| rvalid_o | output | 1 | Read response valid |
| rdata_o | output | 32 | Read response data |

## Verification
The properties assume that rd_size_i never takes the value 3 and that every input is settled before the sampling clock edge. The bench drives each input on the falling edge and uses only the three defined access sizes. Commands are sent as one-cycle strobes, both while the block is ready and deliberately while it is busy. stall_i is held high only across one whole program sequence, which forces the timeout and the abort tail, and it is dropped only after the block is ready again.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_ABORT = 2'd2
  } seq_st_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // status byte bit positions
  localparam int FB_POLL  = 7;
  localparam int FB_TGL   = 6;
  localparam int FB_TMO   = 5;
  localparam int FB_SETUP = 3;
  localparam int FB_TGL2  = 2;
endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int PROG_CYCLES    = 8,
  parameter int ERASE_CYCLES   = 16,
  parameter int SETUP_CYCLES   = 4,
  parameter int TIMEOUT_CYCLES = 24,
  parameter int ABORT_CYCLES   = 4,
  parameter int CW             = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic cmd_erase_i,
  input  logic stall_i,
  output logic rdy_o,
  output logic accept_o,
  output logic commit_o,
  output logic finish_o,
  output logic op_erase_o,
  output logic setup_o,
  output logic tlover_o
);
  seq_st_e         state_q;
  logic [CW-1:0]   prog_cnt_q, elapsed_q, abort_cnt_q;
  logic [CW-1:0]   dur;
  logic            abort_end;

  assign dur       = op_erase_o ? CW'(ERASE_CYCLES) : CW'(PROG_CYCLES);
  assign rdy_o     = (state_q == ST_IDLE);
  assign accept_o  = cmd_valid_i && rdy_o;
  assign commit_o  = (state_q == ST_BUSY) && !stall_i && (prog_cnt_q == dur - CW'(1));
  assign abort_end = (state_q == ST_ABORT) && (abort_cnt_q == CW'(ABORT_CYCLES - 1));
  assign finish_o  = commit_o || abort_end;
  assign setup_o   = op_erase_o && (elapsed_q >= CW'(SETUP_CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      prog_cnt_q  <= '0;
      elapsed_q   <= '0;
      abort_cnt_q <= '0;
      op_erase_o  <= 1'b0;
      tlover_o    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          state_q    <= ST_BUSY;
          prog_cnt_q <= '0;
          elapsed_q  <= '0;
          op_erase_o <= cmd_erase_i;
          tlover_o   <= 1'b0;
        end
        ST_BUSY: begin
          elapsed_q <= elapsed_q + CW'(1);
          if (!stall_i) prog_cnt_q <= prog_cnt_q + CW'(1);
          if (commit_o) begin
            state_q <= ST_IDLE;
          end else if (elapsed_q == CW'(TIMEOUT_CYCLES - 1)) begin
            state_q     <= ST_ABORT;
            abort_cnt_q <= '0;
            tlover_o    <= 1'b1;
          end
        end
        ST_ABORT: begin
          abort_cnt_q <= abort_cnt_q + CW'(1);
          if (abort_end) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_flag_gen.sv
module flash_flag_gen
  import flash_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       op_erase_i,
  input  logic       poll_bit_i,
  input  logic       tlover_i,
  input  logic       setup_i,
  input  logic       flag_rd_i,
  output logic [7:0] flag_o
);
  logic tgl_q, tgl2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q  <= 1'b0;
      tgl2_q <= 1'b0;
    end else if (start_i) begin
      tgl_q  <= 1'b0;
      tgl2_q <= 1'b0;
    end else if (flag_rd_i) begin
      tgl_q <= ~tgl_q;
      if (op_erase_i) tgl2_q <= ~tgl2_q;
    end
  end

  always_comb begin
    flag_o           = '0;
    flag_o[FB_POLL]  = op_erase_i ? 1'b0 : ~poll_bit_i;
    flag_o[FB_TGL]   = tgl_q;
    flag_o[FB_TMO]   = tlover_i;
    flag_o[FB_SETUP] = setup_i;
    flag_o[FB_TGL2]  = tgl2_q;
  end
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [7:0]    cmd_data_i,
  input  logic          commit_i,
  input  logic          op_erase_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [1:0]    rd_size_i,
  output logic [31:0]   rd_word_o,
  output logic [7:0]    pend_data_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] pend_addr_q;
  logic [AW-1:0] base;
  logic [2:0]    nbytes;

  always_comb begin
    unique case (rd_size_i)
      2'd0:    begin base = rd_addr_i;                        nbytes = 3'd1; end
      2'd1:    begin base = rd_addr_i & ~AW'(1);              nbytes = 3'd2; end
      default: begin base = rd_addr_i & ~AW'(3);              nbytes = 3'd4; end
    endcase
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign rd_word_o[8*g +: 8] = (3'(g) < nbytes) ? mem_q[base + AW'(g)] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_addr_q <= '0;
      pend_data_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else begin
      if (start_i) begin
        pend_addr_q <= cmd_addr_i;
        pend_data_o <= cmd_data_i;
      end
      if (commit_i) begin
        if (op_erase_i) begin
          for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
          mem_q[pend_addr_q] <= pend_data_o;
        end
      end
    end
  end
endmodule

// File: rtl/flash_seq_status.sv
module flash_seq_status
  import flash_seq_pkg::*;
#(
  parameter int DEPTH          = 64,
  parameter int PROG_CYCLES    = 8,
  parameter int ERASE_CYCLES   = 16,
  parameter int SETUP_CYCLES   = 4,
  parameter int TIMEOUT_CYCLES = 24,
  parameter int ABORT_CYCLES   = 4,
  localparam int AW            = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_mode_i,
  input  logic          stall_i,
  input  logic          cmd_valid_i,
  input  logic          cmd_erase_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [7:0]    cmd_data_i,
  input  logic          rd_i,
  input  logic [1:0]    rd_size_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          st_we_i,
  input  logic          st_ien_i,
  input  logic          st_clr_i,
  output logic          rdy_o,
  output logic          irq_o,
  output logic [3:0]    status_o,
  output logic          rvalid_o,
  output logic [31:0]   rdata_o
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + ABORT_CYCLES + 1) + 1;

  logic        accept, commit, finish, op_erase, setup_done, tlover;
  logic        flag_sel;
  logic [7:0]  flag_byte, pend_data;
  logic [31:0] arr_word;
  logic        int_flag_q, ien_q;

  flash_seq_ctrl #(
    .PROG_CYCLES   (PROG_CYCLES),
    .ERASE_CYCLES  (ERASE_CYCLES),
    .SETUP_CYCLES  (SETUP_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .ABORT_CYCLES  (ABORT_CYCLES),
    .CW            (CW)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_erase_i(cmd_erase_i),
    .stall_i    (stall_i),
    .rdy_o      (rdy_o),
    .accept_o   (accept),
    .commit_o   (commit),
    .finish_o   (finish),
    .op_erase_o (op_erase),
    .setup_o    (setup_done),
    .tlover_o   (tlover)
  );

  flash_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .cmd_addr_i (cmd_addr_i),
    .cmd_data_i (cmd_data_i),
    .commit_i   (commit),
    .op_erase_i (op_erase),
    .rd_addr_i  (rd_addr_i),
    .rd_size_i  (rd_size_i),
    .rd_word_o  (arr_word),
    .pend_data_o(pend_data)
  );

  // status byte only for odd byte or any half-word read while busy in prog mode
  assign flag_sel = rd_i && prog_mode_i && !rdy_o &&
                    ((rd_size_i == SZ_HALF) || ((rd_size_i == SZ_BYTE) && rd_addr_i[0]));

  flash_flag_gen u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .op_erase_i(op_erase),
    .poll_bit_i(pend_data[7]),
    .tlover_i  (tlover),
    .setup_i   (setup_done),
    .flag_rd_i (flag_sel),
    .flag_o    (flag_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= flag_sel ? {24'h0, flag_byte} : arr_word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_flag_q <= 1'b0;
      ien_q      <= 1'b0;
    end else begin
      if (st_we_i) ien_q <= st_ien_i;
      if (finish)                   int_flag_q <= 1'b1;
      else if (st_we_i && st_clr_i) int_flag_q <= 1'b0;
    end
  end

  assign irq_o    = int_flag_q && ien_q;
  assign status_o = {tlover, ien_q, int_flag_q, rdy_o};
endmodule

// File: rtl/flash_seq_status_chk.sv
module flash_seq_status_chk #(
  parameter int AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          prog_mode_i,
  input logic          cmd_valid_i,
  input logic          rd_i,
  input logic [1:0]    rd_size_i,
  input logic [AW-1:0] rd_addr_i,
  input logic          st_we_i,
  input logic          st_clr_i,
  input logic          rdy_o,
  input logic [3:0]    status_o,
  input logic          rvalid_o,
  input logic [31:0]   rdata_o,
  input logic [7:0]    pend_data
);
  a_r1_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && cmd_valid_i) |=> !rdy_o);

  a_r1_status_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> !status_o[0]);

  a_r2_busy_cmd_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_o && cmd_valid_i) |=> $stable(pend_data));

  a_r3_flag_on_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> status_o[1]);

  a_r3_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] && !(st_we_i && st_clr_i)) |=> status_o[1]);

  a_r4_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  a_r4_flag_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && prog_mode_i && !rdy_o && (rd_size_i == 2'd1 || (rd_size_i == 2'd0 && rd_addr_i[0])))
    |=> (rdata_o[31:8] == 24'h0));

  a_r8_spare_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && prog_mode_i && !rdy_o && (rd_size_i == 2'd1 || (rd_size_i == 2'd0 && rd_addr_i[0])))
    |=> (rdata_o[4] == 1'b0 && rdata_o[1:0] == 2'b00));

  a_r9_tmo_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3] && !(cmd_valid_i && rdy_o)) |=> status_o[3]);
endmodule

bind flash_seq_status flash_seq_status_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .prog_mode_i(prog_mode_i),
  .cmd_valid_i(cmd_valid_i),
  .rd_i       (rd_i),
  .rd_size_i  (rd_size_i),
  .rd_addr_i  (rd_addr_i),
  .st_we_i    (st_we_i),
  .st_clr_i   (st_clr_i),
  .rdy_o      (rdy_o),
  .status_o   (status_o),
  .rvalid_o   (rvalid_o),
  .rdata_o    (rdata_o),
  .pend_data  (pend_data)
);

// File: tb/tb_flash_seq_status.sv
module tb_flash_seq_status;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int PROG  = 8;
  localparam int ERASE = 16;
  localparam int SETUP = 4;
  localparam int TMO   = 24;
  localparam int ABORT = 4;

  logic clk, rst_n;
  logic prog_mode, stall, cmd_valid, cmd_erase, rd, st_we, st_ien, st_clr;
  logic [AW-1:0] cmd_addr, rd_addr;
  logic [7:0]  cmd_data;
  logic [1:0]  rd_size;
  logic        rdy_o, irq_o, rvalid_o;
  logic [3:0]  status_o;
  logic [31:0] rdata_o;

  flash_seq_status #(
    .DEPTH(DEPTH), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE),
    .SETUP_CYCLES(SETUP), .TIMEOUT_CYCLES(TMO), .ABORT_CYCLES(ABORT)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_mode_i(prog_mode), .stall_i(stall),
    .cmd_valid_i(cmd_valid), .cmd_erase_i(cmd_erase), .cmd_addr_i(cmd_addr),
    .cmd_data_i(cmd_data), .rd_i(rd), .rd_size_i(rd_size), .rd_addr_i(rd_addr),
    .st_we_i(st_we), .st_ien_i(st_ien), .st_clr_i(st_clr),
    .rdy_o(rdy_o), .irq_o(irq_o), .status_o(status_o),
    .rvalid_o(rvalid_o), .rdata_o(rdata_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, busy_cnt = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected response when design returns data
  always @(negedge clk) begin
    if (rst_n && rvalid_o) begin
      if (exp_q.size() == 0) chk_eq("R4 unexpected response", rdata_o, 32'hx);
      else chk_eq(tag_q.pop_front(), rdata_o, exp_q.pop_front());
    end
  end

  always @(negedge clk) if (rst_n && !rdy_o) busy_cnt++;

  task automatic rd_exp(input logic [AW-1:0] a, input logic [1:0] sz,
                        input logic [31:0] e, input string t);
    rd = 1'b1; rd_addr = a; rd_size = sz;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic send_cmd(input logic er, input logic [AW-1:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_erase = er; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic st_write(input logic ien, input logic clr);
    st_we = 1'b1; st_ien = ien; st_clr = clr;
    @(negedge clk);
    st_we = 1'b0; st_clr = 1'b0;
  endtask

  task automatic wait_ready();
    while (!rdy_o) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; prog_mode = 1; stall = 0; cmd_valid = 0; cmd_erase = 0;
    cmd_addr = '0; cmd_data = '0; rd = 0; rd_size = 0; rd_addr = '0;
    st_we = 0; st_ien = 0; st_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk_eq("R1 reset rdy", 32'(rdy_o), 32'd1);
    chk_eq("R3 reset status", 32'(status_o), 32'h1);
    chk_eq("R3 reset irq", 32'(irq_o), 32'd0);
    rd_exp(0, 2'd0, 32'h0000_00FF, "R10 reset array byte");

    // program with interrupts enabled
    st_write(1'b1, 1'b0);
    busy_cnt = 0;
    send_cmd(1'b0, 6'd5, 8'h3C);                       // now j=0
    chk_eq("R1 busy after accept", 32'(status_o[0]), 32'd0);
    rd_exp(5, 2'd0, 32'h0000_0080, "R6 poll bit / R7 first read");   // j=0
    rd_exp(2, 2'd1, 32'h0000_00C0, "R4 half flag / R7 toggled");     // j=1
    rd_exp(4, 2'd2, 32'hFFFF_FFFF, "R5 word read gives data");       // j=2
    rd_exp(4, 2'd0, 32'h0000_00FF, "R5 even byte gives data");       // j=3
    prog_mode = 0;
    rd_exp(5, 2'd0, 32'h0000_00FF, "R5 rom mode gives data");        // j=4
    prog_mode = 1;
    send_cmd(1'b1, 6'd0, 8'h00);                       // j=5, ignored erase (R2)
    rd_exp(7, 2'd0, 32'h0000_0080, "R7 toggle only on flag reads");  // j=6
    wait_ready();
    chk_eq("R1 program busy length", 32'(busy_cnt), 32'(PROG));
    chk_eq("R3 irq after program", 32'(irq_o), 32'd1);
    chk_eq("R3 status after program", 32'(status_o), 32'h7);
    rd_exp(4, 2'd2, 32'hFFFF_3CFF, "R10 programmed byte / R2 erase ignored");
    chk_eq("R2 still ready", 32'(rdy_o), 32'd1);
    st_write(1'b1, 1'b1);
    chk_eq("R3 irq cleared", 32'(irq_o), 32'd0);
    chk_eq("R3 flag cleared", 32'(status_o[1]), 32'd0);

    // erase with interrupt disabled
    st_write(1'b0, 1'b0);
    busy_cnt = 0;
    send_cmd(1'b1, 6'd0, 8'h00);                       // j=0
    rd_exp(1, 2'd0, 32'h0000_0000, "R8 before setup");              // j=0
    repeat (4) @(negedge clk);                          // j=5
    rd_exp(3, 2'd0, 32'h0000_004C, "R8 setup and second toggle");   // j=5
    rd_exp(0, 2'd1, 32'h0000_0008, "R8 toggles back");              // j=6
    wait_ready();
    chk_eq("R1 erase busy length", 32'(busy_cnt), 32'(ERASE));
    chk_eq("R3 masked irq", 32'(irq_o), 32'd0);
    chk_eq("R3 flag set while masked", 32'(status_o), 32'h3);
    rd_exp(4, 2'd2, 32'hFFFF_FFFF, "R10 erase fills FF");
    st_write(1'b1, 1'b0);
    chk_eq("R3 irq on enable", 32'(irq_o), 32'd1);
    st_write(1'b1, 1'b1);

    // timeout abort
    stall = 1;
    busy_cnt = 0;
    send_cmd(1'b0, 6'd9, 8'h12);                       // j=0
    repeat (TMO) @(negedge clk);                       // j=TMO, in abort tail
    rd_exp(9, 2'd0, 32'h0000_00A0, "R9 timeout bit in flag");
    rd_exp(8, 2'd1, 32'h0000_00E0, "R9 abort flag toggled");
    wait_ready();
    stall = 0;
    chk_eq("R9 abort busy length", 32'(busy_cnt), 32'(TMO + ABORT));
    chk_eq("R9 status after abort", 32'(status_o), 32'hF);
    chk_eq("R9 irq after abort", 32'(irq_o), 32'd1);
    rd_exp(8, 2'd1, 32'h0000_FFFF, "R9 array unchanged");
    st_write(1'b1, 1'b1);

    // next command clears timeout; poll bit with data bit7=1
    busy_cnt = 0;
    send_cmd(1'b0, 6'd11, 8'h81);
    chk_eq("R9 timeout cleared on accept", 32'(status_o[3]), 32'd0);
    rd_exp(11, 2'd0, 32'h0000_0000, "R6 poll bit inverted");
    wait_ready();
    chk_eq("R1 program busy length 2", 32'(busy_cnt), 32'(PROG));
    rd_exp(11, 2'd0, 32'h0000_0081, "R10 programmed byte 2");
    repeat (3) @(negedge clk);
    chk_eq("R4 all responses seen", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule